// File: doc/BRIEF.md
# Triggered DMA Request Generator

This block holds several independent generator channels that turn events on trigger lines into bursts of DMA requests. Each channel watches one of up to 32 trigger inputs, chosen by its control word. When the chosen line shows the edge type the channel is armed for, the channel raises its request output. It holds the request until the DMA side acknowledges it, and it keeps requesting until the programmed number of acknowledges has come back. The channel then goes idle and waits for the next edge.

A trigger that arrives while a burst is still short of its final request is not queued. It raises a sticky overrun flag for that channel, and the flag drives an interrupt line when the channel's interrupt enable is set. The overrun flags of all channels share one read-only status word and are cleared through a companion write-one-to-clear word. The burst length of a channel can only change while that channel is disabled, so a burst in flight always completes with the length it started with.

Software reaches the block through a simple word-addressed write port and a registered read port. The control word of channel k sits at word address k. The status word is at word address `STAT_ADDR` (default 8) and the clear word is at `CLR_ADDR` (default 9).

Top module: `dmagen_top`

## Requirements
- R1: After a synchronous reset, every control word reads 0, no request is raised, every overrun flag and interrupt is 0 and the read data is 0.
- R2: A control word holds the trigger select in bits 4:0, the interrupt enable in bit 8, the channel enable in bit 16, the edge mode in bits 18:17 and the burst count in bits 23:19. All other bits read back as 0, so writing all ones to a disabled channel reads back 0x00FF011F.
- R3: Edge mode 0 ignores the trigger, 1 reacts to a rising edge, 2 to a falling edge and 3 to both edges. Only the selected trigger line counts, and a disabled channel never reacts.
- R4: On a qualifying edge while idle, the request rises on the next clock. It stays high until acknowledged and continues until exactly burst count + 1 acknowledges have been taken, then drops.
- R5: An edge during a burst sets the channel's overrun flag when fewer than burst-count acknowledges have been taken. Such an edge never restarts or lengthens the burst, and an edge while only the last request is pending is dropped without a flag.
- R6: The status word holds the overrun flag of channel k in bit k and reads 0 elsewhere. Writing 1 to bit k of the clear word clears that flag, writing 0 leaves it, and a set and a clear in the same cycle leave the flag set.
- R7: While a channel is enabled, a write to its control word leaves the burst count unchanged and updates the other fields.
- R8: Clearing the enable aborts a burst: the request is low within two clocks and the next enabled trigger gives a full new burst.
- R9: A channel's interrupt output is high exactly when its overrun flag and its interrupt enable are both set.
- R10: Read data shows, one clock later, the word at the read address sampled at that clock edge. Unmapped addresses and the clear word read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Write strobe for one register word |
| reg_waddr | input | ADDR_W | Word address of the write |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | ADDR_W | Word address of the read |
| reg_rdata | output | 32 | Registered read data |
| trig_in | input | NUM_TRIG | Trigger lines, already synchronous to clk |
| dma_req | output | NUM_CH | Request per channel, held until acknowledged |
| dma_ack | input | NUM_CH | Acknowledge per channel |
| ovr_irq | output | NUM_CH | Overrun interrupt per channel |

## Verification
The bench builds the block with three channels and the full 32 trigger lines. This lets one channel run acknowledged bursts while a second holds a request without acknowledge to provoke overruns, and a third tests the both-edge mode and the dropped edge on a last request. A top trigger select of 31 is used as well. The burst count of 31 is reached through the all-ones write, which also shows the write lock when the enable it sets is withdrawn.

// File: rtl/dmagen_pkg.sv
package dmagen_pkg;

  localparam int WORD_W  = 32;
  localparam int SEL_W   = 5;
  localparam int BURST_W = 5;

  // bit positions of the control word fields (software-visible layout)
  localparam int SEL_LSB   = 0;
  localparam int OIE_BIT   = 8;
  localparam int EN_BIT    = 16;
  localparam int MODE_LSB  = 17;
  localparam int BURST_LSB = 19;

  localparam logic [WORD_W-1:0] BURST_MASK = {{(WORD_W-BURST_W){1'b0}}, {BURST_W{1'b1}}} << BURST_LSB;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_mode_e;

  typedef struct packed {
    logic [BURST_W-1:0] burst;
    edge_mode_e         mode;
    logic               en;
    logic               oie;
    logic [SEL_W-1:0]   sel;
  } chan_cfg_t;

  function automatic logic [WORD_W-1:0] cfg_pack(chan_cfg_t c);
    logic [WORD_W-1:0] w;
    w = '0;
    w[SEL_LSB +: SEL_W]     = c.sel;
    w[OIE_BIT]              = c.oie;
    w[EN_BIT]               = c.en;
    w[MODE_LSB +: 2]        = c.mode;
    w[BURST_LSB +: BURST_W] = c.burst;
    return w;
  endfunction

  function automatic chan_cfg_t cfg_unpack(logic [WORD_W-1:0] w);
    chan_cfg_t c;
    c.sel   = w[SEL_LSB +: SEL_W];
    c.oie   = w[OIE_BIT];
    c.en    = w[EN_BIT];
    c.mode  = edge_mode_e'(w[MODE_LSB +: 2]);
    c.burst = w[BURST_LSB +: BURST_W];
    return c;
  endfunction

endpackage

// File: rtl/dmagen_cfg_reg.sv
module dmagen_cfg_reg
  import dmagen_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [WORD_W-1:0] wdata,
  output chan_cfg_t         cfg
);

  chan_cfg_t incoming;

  always_comb begin
    incoming = cfg_unpack(wdata);
    // burst length frozen while the channel is running
    if (cfg.en) incoming.burst = cfg.burst;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else if (we) begin
      cfg <= incoming;
    end
  end

endmodule

// File: rtl/dmagen_trig_sel.sv
module dmagen_trig_sel
  import dmagen_pkg::*;
#(
  parameter int NUM_TRIG = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_TRIG-1:0] trig_in,
  input  logic [SEL_W-1:0]    sel,
  input  edge_mode_e          mode,
  input  logic                en,
  output logic                hit
);

  localparam int PAD_W = 1 << SEL_W;

  logic [PAD_W-1:0] padded;
  logic             cur;
  logic             prev_q;
  logic             rise;
  logic             fall;

  generate
    if (NUM_TRIG >= PAD_W) begin : g_full
      assign padded = trig_in[PAD_W-1:0];
    end else begin : g_pad
      assign padded = {{(PAD_W-NUM_TRIG){1'b0}}, trig_in};
    end
  endgenerate

  assign cur  = padded[sel];
  assign rise = cur & ~prev_q;
  assign fall = ~cur & prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= cur;
  end

  always_comb begin
    unique case (mode)
      EDGE_RISE: hit = en & rise;
      EDGE_FALL: hit = en & fall;
      EDGE_BOTH: hit = en & (rise | fall);
      default:   hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/dmagen_burst.sv
module dmagen_burst
  import dmagen_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [BURST_W-1:0] burst,
  input  logic               hit,
  input  logic               ack,
  input  logic               clr,
  output logic               req,
  output logic               ovf
);

  logic [BURST_W-1:0] taken_q;
  logic               last_ack;
  logic               overrun;

  assign last_ack = req & ack & (taken_q == burst);
  assign overrun  = hit & req & (taken_q < burst);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      req     <= 1'b0;
      taken_q <= '0;
    end else if (req) begin
      if (last_ack) begin
        req     <= 1'b0;
        taken_q <= '0;
      end else if (ack) begin
        taken_q <= taken_q + 1'b1;
      end
    end else if (hit) begin
      req     <= 1'b1;
      taken_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          ovf <= 1'b0;
    else if (overrun) ovf <= 1'b1;
    else if (clr)     ovf <= 1'b0;
  end

endmodule

// File: rtl/dmagen_top.sv
module dmagen_top
  import dmagen_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int NUM_TRIG  = 32,
  parameter int ADDR_W    = 4,
  parameter int STAT_ADDR = 8,
  parameter int CLR_ADDR  = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_waddr,
  input  logic [31:0]         reg_wdata,
  input  logic [ADDR_W-1:0]   reg_raddr,
  output logic [31:0]         reg_rdata,
  input  logic [NUM_TRIG-1:0] trig_in,
  output logic [NUM_CH-1:0]   dma_req,
  input  logic [NUM_CH-1:0]   dma_ack,
  output logic [NUM_CH-1:0]   ovr_irq
);

  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] CLR_A  = ADDR_W'(CLR_ADDR);

  chan_cfg_t                 cfg   [NUM_CH];
  logic [WORD_W-1:0]         cfg_w [NUM_CH];
  logic [NUM_CH-1:0]         ch_en;
  logic [NUM_CH-1:0]         ch_oie;
  logic [NUM_CH-1:0]         ch_ovf;
  logic [NUM_CH-1:0]         ch_clr;
  logic [NUM_CH*BURST_W-1:0] ch_burst;
  logic [WORD_W-1:0]         rd_next;

  generate
    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
      logic sel_we;
      logic hit;

      assign sel_we    = reg_we && (reg_waddr == ADDR_W'(k));
      assign ch_clr[k] = reg_we && (reg_waddr == CLR_A) && reg_wdata[k];

      dmagen_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (sel_we),
        .wdata (reg_wdata),
        .cfg   (cfg[k])
      );

      dmagen_trig_sel #(.NUM_TRIG(NUM_TRIG)) u_trig (
        .clk     (clk),
        .rst     (rst),
        .trig_in (trig_in),
        .sel     (cfg[k].sel),
        .mode    (cfg[k].mode),
        .en      (cfg[k].en),
        .hit     (hit)
      );

      dmagen_burst u_burst (
        .clk   (clk),
        .rst   (rst),
        .en    (cfg[k].en),
        .burst (cfg[k].burst),
        .hit   (hit),
        .ack   (dma_ack[k]),
        .clr   (ch_clr[k]),
        .req   (dma_req[k]),
        .ovf   (ch_ovf[k])
      );

      assign cfg_w[k]                       = cfg_pack(cfg[k]);
      assign ch_en[k]                       = cfg[k].en;
      assign ch_oie[k]                      = cfg[k].oie;
      assign ch_burst[k*BURST_W +: BURST_W] = cfg[k].burst;
      assign ovr_irq[k]                     = ch_ovf[k] & cfg[k].oie;
    end
  endgenerate

  always_comb begin
    rd_next = '0;
    if (reg_raddr == STAT_A) begin
      rd_next[NUM_CH-1:0] = ch_ovf;
    end else begin
      for (int k = 0; k < NUM_CH; k++) begin
        if (reg_raddr == ADDR_W'(k)) rd_next = cfg_w[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end

endmodule

// File: rtl/dmagen_chk.sv
module dmagen_chk #(
  parameter int NUM_CH  = 4,
  parameter int BURST_W = 5
) (
  input logic                      clk,
  input logic                      rst,
  input logic [NUM_CH-1:0]         dma_req,
  input logic [NUM_CH-1:0]         dma_ack,
  input logic [NUM_CH-1:0]         ovr_irq,
  input logic [NUM_CH-1:0]         ch_en,
  input logic [NUM_CH-1:0]         ch_ovf,
  input logic [NUM_CH-1:0]         ch_clr,
  input logic [NUM_CH*BURST_W-1:0] ch_burst
);

  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dma_req == '0 && ovr_irq == '0));

  generate
    for (genvar k = 0; k < NUM_CH; k++) begin : g_chk
      p_req_held_r4: assert property (@(posedge clk) disable iff (rst)
        (dma_req[k] && !dma_ack[k] && ch_en[k]) |=> dma_req[k]);

      p_ovf_needs_burst_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(ch_ovf[k]) |-> $past(dma_req[k]));

      p_flag_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (ch_ovf[k] && !ch_clr[k]) |=> ch_ovf[k]);

      p_burst_locked_r7: assert property (@(posedge clk) disable iff (rst)
        ch_en[k] |=> $stable(ch_burst[k*BURST_W +: BURST_W]));

      p_disable_drops_r8: assert property (@(posedge clk) disable iff (rst)
        !ch_en[k] |=> !dma_req[k]);
    end
  endgenerate

endmodule

bind dmagen_top dmagen_chk #(.NUM_CH(NUM_CH), .BURST_W(dmagen_pkg::BURST_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .dma_req  (dma_req),
  .dma_ack  (dma_ack),
  .ovr_irq  (ovr_irq),
  .ch_en    (ch_en),
  .ch_ovf   (ch_ovf),
  .ch_clr   (ch_clr),
  .ch_burst (ch_burst)
);

// File: tb/dmagen_top_bench.sv
module dmagen_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NCH        = 3;
  localparam int NTRIG      = 32;
  localparam int SA         = 8;
  localparam int CA         = 9;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             reg_we = 1'b0;
  logic [3:0]       reg_waddr = '0;
  logic [31:0]      reg_wdata = '0;
  logic [3:0]       reg_raddr = '0;
  logic [31:0]      reg_rdata;
  logic [NTRIG-1:0] trig = '0;
  logic [NCH-1:0]   dma_req;
  logic [NCH-1:0]   dma_ack = '0;
  logic [NCH-1:0]   ovr_irq;
  logic [NCH-1:0]   auto_ack = '0;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference model state
  logic [31:0] m_ctrl [NCH];
  bit          m_act  [NCH];
  int          m_cnt  [NCH];
  bit          m_ovf  [NCH];
  bit          m_prev [NCH];
  logic [31:0] m_rdata;
  int          acks   [NCH];

  dmagen_top #(.NUM_CH(NCH), .NUM_TRIG(NTRIG), .ADDR_W(4), .STAT_ADDR(SA), .CLR_ADDR(CA)) u_dmagen_top (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_waddr (reg_waddr),
    .reg_wdata (reg_wdata),
    .reg_raddr (reg_raddr),
    .reg_rdata (reg_rdata),
    .trig_in   (trig),
    .dma_req   (dma_req),
    .dma_ack   (dma_ack),
    .ovr_irq   (ovr_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) dma_ack <= auto_ack & dma_req;

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NCH; c++) begin
        m_ctrl[c] = '0; m_act[c] = 0; m_cnt[c] = 0; m_ovf[c] = 0; m_prev[c] = 0; acks[c] = 0;
      end
      m_rdata = '0;
    end else begin
      logic [31:0] nr;
      nr = '0;
      if (reg_raddr < NCH) nr = m_ctrl[reg_raddr];
      else if (reg_raddr == SA) for (int c = 0; c < NCH; c++) nr[c] = m_ovf[c];
      for (int c = 0; c < NCH; c++) begin
        int  bl, md;
        bit  en, cur, ev, setf, clrf;
        bl  = int'(m_ctrl[c][23:19]);
        md  = int'(m_ctrl[c][18:17]);
        en  = m_ctrl[c][16];
        cur = trig[m_ctrl[c][4:0]];
        ev  = en && ((md == 1 && cur && !m_prev[c]) || (md == 2 && !cur && m_prev[c]) ||
                     (md == 3 && cur != m_prev[c]));
        if (m_act[c] && dma_ack[c]) acks[c]++;
        setf = ev && m_act[c] && (m_cnt[c] < bl);
        clrf = reg_we && reg_waddr == CA && reg_wdata[c];
        if (!en) begin
          m_act[c] = 0; m_cnt[c] = 0;
        end else if (m_act[c]) begin
          if (dma_ack[c]) begin
            if (m_cnt[c] == bl) begin m_act[c] = 0; m_cnt[c] = 0; end
            else m_cnt[c]++;
          end
        end else if (ev) begin
          m_act[c] = 1; m_cnt[c] = 0;
        end
        if (setf) m_ovf[c] = 1;
        else if (clrf) m_ovf[c] = 0;
        m_prev[c] = cur;
        if (reg_we && reg_waddr == c) begin
          if (en) m_ctrl[c] = (reg_wdata & 32'h0007011F) | (m_ctrl[c] & 32'h00F80000);
          else    m_ctrl[c] = reg_wdata & 32'h00FF011F;
        end
      end
      m_rdata = nr;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      logic [NCH-1:0] er, ei;
      for (int c = 0; c < NCH; c++) begin
        er[c] = m_act[c];
        ei[c] = m_ovf[c] && m_ctrl[c][8];
      end
      check("R4 request", 32'(dma_req), 32'(er));
      check("R9 interrupt", 32'(ovr_irq), 32'(ei));
      check("R10 read data", reg_rdata, m_rdata);
    end
  end

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_waddr = 4'(a); reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(int a, output logic [31:0] v);
    @(negedge clk); reg_raddr = 4'(a);
    @(negedge clk); v = reg_rdata;
  endtask

  task automatic set_trig(int k, bit v, int n);
    @(negedge clk); trig[k] = v;
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] word(int sel, bit oie, bit en, int md, int bl);
    return 32'(sel) | (32'(oie) << 8) | (32'(en) << 16) | (32'(md) << 17) | (32'(bl) << 19);
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL R4 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int base;
    repeat (4) @(negedge clk);
    rst = 0;
    // R1 reset values
    rd(0, v);  check("R1 ctrl0 after reset", v, 32'h0);
    rd(SA, v); check("R1 status after reset", v, 32'h0);
    check("R1 no request", 32'(dma_req), 32'h0);

    // R2 layout and R7 lock
    wr(2, 32'hFFFFFFFF);
    rd(2, v); check("R2 readback all ones", v, 32'h00FF011F);
    wr(2, 32'h0);
    rd(2, v); check("R7 burst kept while enabled", v, 32'h00F80000);
    wr(2, 32'h0);
    rd(2, v); check("R7 burst writable when disabled", v, 32'h0);

    // R4 burst of 3 on rising edge of line 5
    auto_ack = 3'b111;
    wr(0, word(5, 0, 1, 1, 2));
    rd(0, v); check("R2 ctrl0 readback", v, word(5, 0, 1, 1, 2));
    base = acks[0];
    set_trig(5, 1, 12);
    check("R4 burst length 3", 32'(acks[0] - base), 32'd3);
    set_trig(5, 0, 4);
    set_trig(6, 1, 10);
    check("R3 falling edge and other line ignored", 32'(acks[0] - base), 32'd3);
    set_trig(6, 0, 2);

    // R3 mode none
    wr(0, word(5, 0, 1, 0, 2));
    base = acks[0];
    set_trig(5, 1, 4); set_trig(5, 0, 6);
    check("R3 mode none ignores edges", 32'(acks[0] - base), 32'd0);

    // R5 overrun on channel 1, falling mode, burst 4, no ack
    auto_ack[1] = 0;
    wr(1, word(7, 0, 1, 2, 3));
    set_trig(7, 1, 2); set_trig(7, 0, 4);
    check("R4 request held without ack", 32'(dma_req[1]), 32'd1);
    set_trig(7, 1, 2); set_trig(7, 0, 2);
    rd(SA, v); check("R5 overrun flag set", v, 32'h2);
    check("R9 interrupt masked", 32'(ovr_irq[1]), 32'd0);
    wr(1, word(7, 1, 1, 2, 3));
    @(negedge clk);
    check("R9 interrupt enabled", 32'(ovr_irq[1]), 32'd1);
    wr(CA, 32'h0);
    rd(SA, v); check("R6 zero write keeps flag", v, 32'h2);
    wr(CA, 32'h2);
    rd(SA, v); check("R6 one write clears flag", v, 32'h0);

    // R8 abort and full restart
    wr(1, word(7, 1, 0, 2, 3));
    repeat (2) @(negedge clk);
    check("R8 request dropped on disable", 32'(dma_req[1]), 32'd0);
    wr(1, word(7, 1, 1, 2, 3));
    auto_ack[1] = 1;
    base = acks[1];
    set_trig(7, 1, 2); set_trig(7, 0, 15);
    check("R8 full burst after restart", 32'(acks[1] - base), 32'd4);

    // R6 set wins over same-cycle clear
    auto_ack[1] = 0;
    set_trig(7, 1, 2); set_trig(7, 0, 3);
    set_trig(7, 1, 2);
    @(negedge clk); trig[7] = 0; reg_we = 1; reg_waddr = 4'(CA); reg_wdata = 32'h2;
    @(negedge clk); reg_we = 0;
    rd(SA, v); check("R6 set beats clear", v, 32'h2);
    wr(CA, 32'h2);
    rd(SA, v); check("R6 cleared again", v, 32'h0);

    // R5 edge on last pending request: dropped, no flag; R3 both edges
    auto_ack[2] = 0;
    wr(2, word(0, 0, 1, 3, 0));
    base = acks[2];
    set_trig(0, 1, 3); set_trig(0, 0, 3);
    rd(SA, v); check("R5 no flag on last request", 32'(v[2]), 32'd0);
    auto_ack[2] = 1;
    repeat (6) @(negedge clk);
    check("R5 burst not extended", 32'(acks[2] - base), 32'd1);
    base = acks[2];
    set_trig(0, 1, 6); set_trig(0, 0, 6);
    check("R3 both edges give two bursts", 32'(acks[2] - base), 32'd2);

    // R3 top select line 31
    wr(2, 32'h0);
    wr(2, word(31, 0, 1, 1, 0));
    base = acks[2];
    set_trig(31, 1, 6);
    check("R3 select line 31", 32'(acks[2] - base), 32'd1);

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule